// File: doc/BRIEF.md
# Private Peripheral Bus Router

This block sits between a processor's load/store port and the small register blocks in its 1 MB private peripheral window. The window starts at 0xE0000000. For each request it picks one destination: the system-control register port, one of two banked tick-timer ports, an optional error-record register port, or a local responder. The local responder answers for every address in the window that no block claims. The decision is made in the same cycle from the address, the security attribute and the privilege attribute. Overlapping regions are resolved by fixed priority.

When the security option is built in, a second 4 KB page at 0xE002E000 mirrors the system-control page for secure software. A secure access through this mirror reaches the real block as a non-secure access. A non-secure access to the mirror is answered locally. The router holds no state. It only steers the request, forwards the attributes, and selects which response comes back.

The request side is a valid/ready channel. A request is accepted in the cycle where both `req_valid` and `req_ready` are high. `req_ready` is the ready of whichever destination was selected, so a slow target holds the requester off. The requester must keep the request stable while `req_ready` is low. The response (`rsp_rdata`, `rsp_err`) is valid in the accepting cycle. Each target port is also valid/ready: its valid is raised only while it is selected and `req_valid` is high.

Top module: `ppb_router`

## Requirements
- R1: A request whose address lies outside 0xE0000000–0xE00FFFFF raises `out_of_range`. It raises no target valid, and `req_ready` stays low.
- R2: With `req_valid` high and the address in the window, exactly one destination is selected: one of the four target ports or the local responder. With `req_valid` low, no target valid is raised.
- R3: An address in page 0xE000E000–0xE000EFFF outside the timer span goes to the system-control port with the request's security attribute unchanged. `tgt_offset` carries address bits 11:0.
- R4: Page offsets 0x010 to 0x0EF of the system-control page go to a timer port, which takes priority over the system-control port. A secure request selects the secure timer port and a non-secure one selects the non-secure timer port. Offsets 0x00C and 0x0F0 stay with system control.
- R5: An unclaimed window address is served by the local responder. It is ready at once. For a privileged request it reads zero and reports no error, and a write reaches no target. For an unprivileged (user) request it reports an error.
- R6: With the security option on, a secure access to page 0xE002E000 is forwarded with `tgt_secure` low. Offsets 0x010–0x0EF go to the non-secure timer port and the rest go to the system-control port, both with the same `tgt_offset`.
- R7: With the security option on, a non-secure access to page 0xE002E000 reaches no target. It reads zero with no error when privileged, and reports an error when unprivileged.
- R8: With the error-record option on, page 0xE0005000 goes to the error-record port, and its response error is returned on `rsp_err`.
- R9: With the security option off, page 0xE002E000 is unclaimed, and a secure timer access goes to the non-secure timer port. With the error-record option off, page 0xE0005000 is unclaimed.
- R10: `req_ready`, `rsp_rdata` and `rsp_err` come from the selected destination in the same cycle. `tgt_write`, `tgt_wdata` and `tgt_size` equal the request fields. All four size codes are accepted: 0 means 1 byte, 1 means 2, 2 means 4 and 3 means 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded checks |
| rst_n | input | 1 | Active-low reset for the embedded checks |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | ADDR_W | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| req_size | input | 2 | log2 of the byte count |
| req_secure | input | 1 | Security attribute of the request |
| req_user | input | 1 | Unprivileged request |
| rsp_rdata | output | DATA_W | Read data of the accepted request |
| rsp_err | output | 1 | Bus error for the accepted request |
| out_of_range | output | 1 | Address outside the window |
| tgt_offset | output | PAGE_BITS | Offset within the 4 KB page |
| tgt_write | output | 1 | Forwarded direction |
| tgt_wdata | output | DATA_W | Forwarded write data |
| tgt_size | output | 2 | Forwarded size code |
| tgt_secure | output | 1 | Forwarded, possibly cleared, security attribute |
| sc_valid | output | 1 | System-control request |
| sc_ready | input | 1 | System-control ready |
| sc_rdata | input | DATA_W | System-control read data |
| sc_err | input | 1 | System-control error |
| tkn_valid | output | 1 | Non-secure timer request |
| tkn_ready | input | 1 | Non-secure timer ready |
| tkn_rdata | input | DATA_W | Non-secure timer read data |
| tkn_err | input | 1 | Non-secure timer error |
| tks_valid | output | 1 | Secure timer request |
| tks_ready | input | 1 | Secure timer ready |
| tks_rdata | input | DATA_W | Secure timer read data |
| tks_err | input | 1 | Secure timer error |
| er_valid | output | 1 | Error-record request |
| er_ready | input | 1 | Error-record ready |
| er_rdata | input | DATA_W | Error-record read data |
| er_err | input | 1 | Error-record error |

## Verification
The bench builds two copies of the router that share the same stimulus. The first has both the security option and the error-record option on, so the mirror page, the banked secure timer and the error-record page can all be reached. The second has both options off, so the same addresses must fall through to the local responder and secure timer traffic must land on the non-secure port. Each target is given its own read-data signature and some targets report errors. This makes a wrong response selection visible at the ports. One scenario stalls a target to show that its ready is passed back to the requester.

// File: rtl/ppb_pkg.sv
package ppb_pkg;

  typedef enum logic [2:0] {
    DST_NONE,
    DST_LOCAL,
    DST_SYSCTL,
    DST_TICK_NS,
    DST_TICK_S,
    DST_ERRREC
  } dst_e;

  localparam int unsigned NUM_PORTS = 4;

  typedef struct packed {
    logic in_window;
    logic sys_page;
    logic tick_span;
    logic alias_page;
    logic err_page;
  } hit_t;

  function automatic dst_e slot_dst(int unsigned slot);
    case (slot)
      0:       return DST_SYSCTL;
      1:       return DST_TICK_NS;
      2:       return DST_TICK_S;
      default: return DST_ERRREC;
    endcase
  endfunction

endpackage

// File: rtl/ppb_region_match.sv
module ppb_region_match
  import ppb_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned WIN_BITS     = 20,
  parameter int unsigned PAGE_BITS    = 12,
  parameter logic [31:0] WIN_BASE     = 32'hE000_0000,
  parameter logic [31:0] SYS_BASE     = 32'hE000_E000,
  parameter logic [31:0] ALIAS_BASE   = 32'hE002_E000,
  parameter logic [31:0] ERR_BASE     = 32'hE000_5000,
  parameter int unsigned TICK_LO      = 'h010,
  parameter int unsigned TICK_SIZE    = 'h0E0,
  parameter bit          HAS_SECURITY = 1'b1,
  parameter bit          HAS_ERRREC   = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  output hit_t              hit
);
  localparam int unsigned TICK_HI = TICK_LO + TICK_SIZE;
  localparam int unsigned WTOP    = ADDR_W - WIN_BITS;
  localparam int unsigned PTOP    = ADDR_W - PAGE_BITS;

  logic [PAGE_BITS-1:0] ofs;
  logic                 ofs_in_tick;
  logic                 alias_hit;
  logic                 err_hit;

  assign ofs = addr[PAGE_BITS-1:0];
  assign ofs_in_tick = (32'(ofs) >= TICK_LO) && (32'(ofs) < TICK_HI);

  generate
    if (HAS_SECURITY) begin : g_alias
      assign alias_hit = addr[ADDR_W-1:PAGE_BITS] == ALIAS_BASE[ADDR_W-1:PAGE_BITS];
    end else begin : g_no_alias
      assign alias_hit = 1'b0;
    end
    if (HAS_ERRREC) begin : g_err
      assign err_hit = addr[ADDR_W-1:PAGE_BITS] == ERR_BASE[ADDR_W-1:PAGE_BITS];
    end else begin : g_no_err
      assign err_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    hit.in_window  = addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS];
    hit.sys_page   = addr[ADDR_W-1:PAGE_BITS] == SYS_BASE[ADDR_W-1:PAGE_BITS];
    hit.tick_span  = ofs_in_tick;
    hit.alias_page = alias_hit;
    hit.err_page   = err_hit;
  end

  initial begin
    if (WTOP == 0 || PTOP == 0) $display("ppb_region_match: degenerate widths");
  end
endmodule

// File: rtl/ppb_route_select.sv
module ppb_route_select
  import ppb_pkg::*;
#(
  parameter bit HAS_SECURITY = 1'b1
) (
  input  hit_t hit,
  input  logic secure,
  output dst_e dst,
  output logic fwd_secure
);
  always_comb begin
    dst        = DST_LOCAL;
    fwd_secure = secure;
    if (!hit.in_window) begin
      dst = DST_NONE;
    end else if (hit.alias_page) begin
      if (secure) begin
        fwd_secure = 1'b0;
        dst        = hit.tick_span ? DST_TICK_NS : DST_SYSCTL;
      end else begin
        dst = DST_LOCAL;
      end
    end else if (hit.sys_page && hit.tick_span) begin
      dst = (HAS_SECURITY && secure) ? DST_TICK_S : DST_TICK_NS;
    end else if (hit.sys_page) begin
      dst = DST_SYSCTL;
    end else if (hit.err_page) begin
      dst = DST_ERRREC;
    end
  end
endmodule

// File: rtl/ppb_resp_mux.sv
module ppb_resp_mux
  import ppb_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  dst_e                          dst,
  input  logic                          user,
  input  logic [NUM_PORTS-1:0]          t_ready,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0] t_rdata,
  input  logic [NUM_PORTS-1:0]          t_err,
  output logic                          ready,
  output logic [DATA_W-1:0]             rdata,
  output logic                          err
);
  always_comb begin
    ready = 1'b0;
    rdata = '0;
    err   = 1'b0;
    if (dst == DST_LOCAL) begin
      ready = 1'b1;
      err   = user;
    end else begin
      for (int unsigned i = 0; i < NUM_PORTS; i++) begin
        if (dst == slot_dst(i)) begin
          ready = t_ready[i];
          rdata = t_rdata[i];
          err   = t_err[i];
        end
      end
    end
  end
endmodule

// File: rtl/ppb_router.sv
module ppb_router
  import ppb_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned DATA_W       = 64,
  parameter int unsigned PAGE_BITS    = 12,
  parameter bit          HAS_SECURITY = 1'b1,
  parameter bit          HAS_ERRREC   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_write,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic [1:0]           req_size,
  input  logic                 req_secure,
  input  logic                 req_user,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 rsp_err,
  output logic                 out_of_range,
  output logic [PAGE_BITS-1:0] tgt_offset,
  output logic                 tgt_write,
  output logic [DATA_W-1:0]    tgt_wdata,
  output logic [1:0]           tgt_size,
  output logic                 tgt_secure,
  output logic                 sc_valid,
  input  logic                 sc_ready,
  input  logic [DATA_W-1:0]    sc_rdata,
  input  logic                 sc_err,
  output logic                 tkn_valid,
  input  logic                 tkn_ready,
  input  logic [DATA_W-1:0]    tkn_rdata,
  input  logic                 tkn_err,
  output logic                 tks_valid,
  input  logic                 tks_ready,
  input  logic [DATA_W-1:0]    tks_rdata,
  input  logic                 tks_err,
  output logic                 er_valid,
  input  logic                 er_ready,
  input  logic [DATA_W-1:0]    er_rdata,
  input  logic                 er_err
);
  hit_t                             hit;
  dst_e                             dst;
  logic [NUM_PORTS-1:0]             port_valid;
  logic [NUM_PORTS-1:0]             port_ready;
  logic [NUM_PORTS-1:0][DATA_W-1:0] port_rdata;
  logic [NUM_PORTS-1:0]             port_err;
  logic                             local_sel;

  ppb_region_match #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS),
    .HAS_SECURITY(HAS_SECURITY), .HAS_ERRREC(HAS_ERRREC)
  ) u_match (
    .addr(req_addr),
    .hit (hit)
  );

  ppb_route_select #(.HAS_SECURITY(HAS_SECURITY)) u_select (
    .hit       (hit),
    .secure    (req_secure),
    .dst       (dst),
    .fwd_secure(tgt_secure)
  );

  assign port_ready = {er_ready, tks_ready, tkn_ready, sc_ready};
  assign port_err   = {er_err, tks_err, tkn_err, sc_err};
  assign port_rdata = {er_rdata, tks_rdata, tkn_rdata, sc_rdata};

  generate
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_strobe
      assign port_valid[g] = req_valid && (dst == slot_dst(g));
    end
  endgenerate

  assign {er_valid, tks_valid, tkn_valid, sc_valid} = port_valid;
  assign local_sel = req_valid && (dst == DST_LOCAL);

  ppb_resp_mux #(.DATA_W(DATA_W)) u_resp (
    .dst    (dst),
    .user   (req_user),
    .t_ready(port_ready),
    .t_rdata(port_rdata),
    .t_err  (port_err),
    .ready  (req_ready),
    .rdata  (rsp_rdata),
    .err    (rsp_err)
  );

  assign out_of_range = !hit.in_window;
  assign tgt_offset   = req_addr[PAGE_BITS-1:0];
  assign tgt_write    = req_write;
  assign tgt_wdata    = req_wdata;
  assign tgt_size     = req_size;

  // R1: outside the window nothing is claimed or accepted
  assert_oor_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && out_of_range |-> (port_valid == '0) && !req_ready);

  // R2: exactly one destination inside the window
  assert_one_dest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && hit.in_window |-> $countones({port_valid, local_sel}) == 1);

  // R4: secure timer bank only sees secure traffic
  assert_tick_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tks_valid |-> req_secure && tgt_secure);

  // R5: unprivileged access to an unclaimed address faults
  assert_user_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    local_sel && req_user |-> rsp_err && req_ready);

  // R6: mirror page forwards with the attribute cleared
  assert_alias_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && hit.alias_page && req_secure |-> !tgt_secure && !tks_valid);

  // R7: non-secure mirror access reaches no target
  assert_alias_ns_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && hit.alias_page && !req_secure |-> port_valid == '0);
endmodule

// File: tb/ppb_router_bench.sv
module ppb_router_bench;
  localparam int unsigned DW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid, req_write, req_secure, req_user;
  logic [31:0]   req_addr;
  logic [DW-1:0] req_wdata;
  logic [1:0]    req_size;
  logic          sc_ready, tkn_ready, tks_ready, er_ready;
  logic [DW-1:0] sc_rdata, tkn_rdata, tks_rdata, er_rdata;
  logic          sc_err, tkn_err, tks_err, er_err;

  logic          req_ready, rsp_err, out_of_range, tgt_write, tgt_secure;
  logic [DW-1:0] rsp_rdata, tgt_wdata;
  logic [11:0]   tgt_offset;
  logic [1:0]    tgt_size;
  logic          sc_valid, tkn_valid, tks_valid, er_valid;

  logic          l_req_ready, l_rsp_err, l_oor, l_tgt_write, l_tgt_secure;
  logic [DW-1:0] l_rsp_rdata, l_tgt_wdata;
  logic [11:0]   l_tgt_offset;
  logic [1:0]    l_tgt_size;
  logic          l_sc_valid, l_tkn_valid, l_tks_valid, l_er_valid;

  ppb_router u_ppb_router (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .req_size(req_size), .req_secure(req_secure), .req_user(req_user),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .out_of_range(out_of_range),
    .tgt_offset(tgt_offset), .tgt_write(tgt_write), .tgt_wdata(tgt_wdata),
    .tgt_size(tgt_size), .tgt_secure(tgt_secure),
    .sc_valid(sc_valid), .sc_ready(sc_ready), .sc_rdata(sc_rdata), .sc_err(sc_err),
    .tkn_valid(tkn_valid), .tkn_ready(tkn_ready), .tkn_rdata(tkn_rdata), .tkn_err(tkn_err),
    .tks_valid(tks_valid), .tks_ready(tks_ready), .tks_rdata(tks_rdata), .tks_err(tks_err),
    .er_valid(er_valid), .er_ready(er_ready), .er_rdata(er_rdata), .er_err(er_err)
  );

  ppb_router #(.HAS_SECURITY(1'b0), .HAS_ERRREC(1'b0)) u_ppb_router_lean (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(l_req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .req_size(req_size), .req_secure(req_secure), .req_user(req_user),
    .rsp_rdata(l_rsp_rdata), .rsp_err(l_rsp_err), .out_of_range(l_oor),
    .tgt_offset(l_tgt_offset), .tgt_write(l_tgt_write), .tgt_wdata(l_tgt_wdata),
    .tgt_size(l_tgt_size), .tgt_secure(l_tgt_secure),
    .sc_valid(l_sc_valid), .sc_ready(sc_ready), .sc_rdata(sc_rdata), .sc_err(sc_err),
    .tkn_valid(l_tkn_valid), .tkn_ready(tkn_ready), .tkn_rdata(tkn_rdata), .tkn_err(tkn_err),
    .tks_valid(l_tks_valid), .tks_ready(tks_ready), .tks_rdata(tks_rdata), .tks_err(tks_err),
    .er_valid(l_er_valid), .er_ready(er_ready), .er_rdata(er_rdata), .er_err(er_err)
  );

  int total = 0;
  int bad   = 0;

  // route codes: 0 sysctl, 1 timer ns, 2 timer s, 3 error-record, 4 none
  localparam int R_SC = 0, R_TN = 1, R_TS = 2, R_ER = 3, R_NO = 4;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] onehot(int code);
    return (code < 4) ? 4'(1 << code) : 4'b0000;
  endfunction

  task automatic issue(logic [31:0] a, logic sec, logic usr, logic wr);
    @(negedge clk);
    req_valid  = 1'b1;
    req_addr   = a;
    req_secure = sec;
    req_user   = usr;
    req_write  = wr;
    #2;
  endtask

  task automatic expect_route(string req, int code);
    chk(req, {60'd0, er_valid, tks_valid, tkn_valid, sc_valid}, {60'd0, onehot(code)});
  endtask

  task automatic t_reset_idle();
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = 32'hE000_E010;
    #2;
    chk("R2 idle", {60'd0, er_valid, tks_valid, tkn_valid, sc_valid}, 64'd0);
  endtask

  task automatic t_window();
    issue(32'h2000_0000, 1'b1, 1'b0, 1'b0);
    chk("R1 oor low", out_of_range, 1);
    expect_route("R1 oor low route", R_NO);
    chk("R1 oor ready", req_ready, 0);
    issue(32'hE010_0000, 1'b0, 1'b0, 1'b0);
    chk("R1 oor above", out_of_range, 1);
    chk("R1 oor above ready", req_ready, 0);
    issue(32'hE00F_FFFC, 1'b0, 1'b0, 1'b0);
    chk("R1 top in window", out_of_range, 0);
  endtask

  task automatic t_sysctl();
    issue(32'hE000_ED04, 1'b1, 1'b0, 1'b0);
    expect_route("R3 sysctl sec", R_SC);
    chk("R3 sec kept", tgt_secure, 1);
    chk("R3 offset", tgt_offset, 12'hD04);
    chk("R3 rdata", rsp_rdata, sc_rdata);
    issue(32'hE000_E004, 1'b0, 1'b1, 1'b0);
    expect_route("R3 sysctl ns", R_SC);
    chk("R3 ns kept", tgt_secure, 0);
  endtask

  task automatic t_timer();
    issue(32'hE000_E010, 1'b1, 1'b0, 1'b0);
    expect_route("R4 secure bank", R_TS);
    chk("R4 secure data", rsp_rdata, tks_rdata);
    issue(32'hE000_E010, 1'b0, 1'b0, 1'b0);
    expect_route("R4 ns bank", R_TN);
    chk("R4 ns data", rsp_rdata, tkn_rdata);
    issue(32'hE000_E0EC, 1'b0, 1'b0, 1'b0);
    expect_route("R4 last word", R_TN);
    issue(32'hE000_E0F0, 1'b1, 1'b0, 1'b0);
    expect_route("R4 above span", R_SC);
    issue(32'hE000_E00C, 1'b1, 1'b0, 1'b0);
    expect_route("R4 below span", R_SC);
  endtask

  task automatic t_default();
    for (int s = 0; s < 4; s++) begin
      req_size = 2'(s);
      issue(32'hE000_1000, 1'b0, 1'b0, 1'b0);
      expect_route("R5 default route", R_NO);
      chk("R5 raz data", rsp_rdata, 0);
      chk("R10 size accepted", {req_ready, rsp_err}, 2'b10);
      chk("R10 size fwd", tgt_size, s);
    end
    issue(32'hE000_2000, 1'b1, 1'b0, 1'b1);
    expect_route("R5 write ignored", R_NO);
    chk("R5 write no err", rsp_err, 0);
    issue(32'hE000_1000, 1'b1, 1'b1, 1'b0);
    chk("R5 user fault", {req_ready, rsp_err}, 2'b11);
  endtask

  task automatic t_alias_secure();
    issue(32'hE002_ED00, 1'b1, 1'b0, 1'b0);
    expect_route("R6 alias sysctl", R_SC);
    chk("R6 attr cleared", tgt_secure, 0);
    chk("R6 offset", tgt_offset, 12'hD00);
    issue(32'hE002_E010, 1'b1, 1'b0, 1'b0);
    expect_route("R6 alias timer ns", R_TN);
    chk("R6 alias timer attr", tgt_secure, 0);
  endtask

  task automatic t_alias_nonsecure();
    issue(32'hE002_ED00, 1'b0, 1'b0, 1'b1);
    expect_route("R7 alias ns priv", R_NO);
    chk("R7 priv raz", {req_ready, rsp_err, rsp_rdata}, {2'b10, 64'd0});
    issue(32'hE002_E010, 1'b0, 1'b1, 1'b0);
    expect_route("R7 alias ns user", R_NO);
    chk("R7 user fault", rsp_err, 1);
  endtask

  task automatic t_errrec();
    issue(32'hE000_5008, 1'b0, 1'b0, 1'b0);
    expect_route("R8 errrec", R_ER);
    chk("R8 err returned", rsp_err, 1);
    chk("R8 data", rsp_rdata, er_rdata);
  endtask

  task automatic t_lean();
    issue(32'hE002_ED00, 1'b1, 1'b0, 1'b0);
    chk("R9 no alias", {60'd0, l_er_valid, l_tks_valid, l_tkn_valid, l_sc_valid}, 64'd0);
    chk("R9 alias raz", {l_req_ready, l_rsp_err, l_rsp_rdata}, {2'b10, 64'd0});
    issue(32'hE000_E020, 1'b1, 1'b0, 1'b0);
    chk("R9 single bank", {60'd0, l_er_valid, l_tks_valid, l_tkn_valid, l_sc_valid}, 64'd2);
    issue(32'hE000_5000, 1'b0, 1'b1, 1'b0);
    chk("R9 no errrec", {60'd0, l_er_valid, l_tks_valid, l_tkn_valid, l_sc_valid}, 64'd0);
    chk("R9 no errrec fault", l_rsp_err, 1);
  endtask

  task automatic t_handshake();
    req_wdata = 64'hDEAD_BEEF_0123_4567;
    req_size  = 2'd2;
    issue(32'hE000_ED10, 1'b1, 1'b0, 1'b1);
    sc_ready = 1'b0;
    #1;
    chk("R10 stall", req_ready, 0);
    chk("R10 held valid", sc_valid, 1);
    sc_ready = 1'b1;
    #1;
    chk("R10 release", req_ready, 1);
    chk("R10 wdata", tgt_wdata, 64'hDEAD_BEEF_0123_4567);
    chk("R10 write", tgt_write, 1);
    chk("R10 size", tgt_size, 2);
    tkn_err = 1'b1;
    issue(32'hE000_E018, 1'b0, 1'b0, 1'b0);
    chk("R10 err mux", rsp_err, 1);
    tkn_err = 1'b0;
  endtask

  initial begin
    req_valid = 0; req_write = 0; req_secure = 0; req_user = 0;
    req_addr = 0; req_wdata = 0; req_size = 0;
    sc_ready = 1; tkn_ready = 1; tks_ready = 1; er_ready = 1;
    sc_rdata  = 64'h0000_5C00_0000_0001;
    tkn_rdata = 64'h0000_0000_0000_0071;
    tks_rdata = 64'h0000_0000_0000_0072;
    er_rdata  = 64'h0000_0000_0000_003E;
    sc_err = 0; tkn_err = 0; tks_err = 0; er_err = 1;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_idle();
    t_window();
    t_sysctl();
    t_timer();
    t_default();
    t_alias_secure();
    t_alias_nonsecure();
    t_errrec();
    t_lean();
    t_handshake();
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule